// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This block turns the system clock into time quanta and cuts each bit on a CAN-style serial bus into a one-quantum sync segment, a first phase segment and a second phase segment. The receive line is sampled at the end of the first phase segment. Sampling uses either the single value taken there or a two-of-three majority of that value and the values taken one and two quanta earlier. The block reports the sampled bit, a sample strobe, a transmit-point strobe and a bit-boundary strobe to the protocol logic around it.

Two configuration words set the block up. One holds the prescaler and the resynchronization limit. The other holds both phase-segment lengths and the sampling mode. Neither word can be written unless the controller is held in soft reset. The receive line is observed once per quantum. A recessive-to-dominant change moves the bit boundary. While the bus is idle or the controller is in soft reset, the change restarts the bit outright. Otherwise it stretches the first phase segment or trims the second one, and never by more than the jump width.

Top module: `can_bit_timer`

## Requirements
- R1: The quantum lasts P = BRP+1 clocks, where BRP is `presc_wdata[5:0]`. A bit with no bus edges lasts 1 + (TS1+1) + (TS2+1) quanta, which sets the spacing of `bit_start` pulses.
- R2: `tx_stb` pulses one quantum after a normal `bit_start`. `sample_stb` pulses (TS1+2) quanta after `bit_start`, at the end of the first phase segment. The two strobes never coincide with `bit_start`.
- R3: The prescaler/jump-width word is laid out as `[7:6]` SJW and `[5:0]` BRP. The timing word is laid out as `[7]` triple-sample, `[6:4]` TS2 and `[3:0]` TS1. A write to either word while `soft_rst` is 0 leaves the bit timing unchanged.
- R4: When triple-sample is 0, `rx_bit` takes the line value at the sample point alone. `rx_bit` changes only together with `sample_stb`.
- R5: When triple-sample is 1, `rx_bit` is the majority of the line values at the sample point and one and two quanta before it.
- R6: A falling edge seen in quantum q (counting from 0) of the first phase segment lengthens that segment by min(q+1, SJW+1) quanta.
- R7: A falling edge in quantum q of the second phase segment, which has length L, is handled in one of two ways. If L−q ≤ SJW+1, that quantum becomes the next bit's sync segment, and `bit_start` and `tx_stb` pulse at its end. Otherwise the segment is shortened by SJW+1 quanta.
- R8: A falling edge that falls in the sync segment changes no timing.
- R9: At most one adjustment is made per bit, and rising edges never adjust.
- R10: While `bus_idle` or `soft_rst` is 1, a falling edge makes the quantum in which it is seen the sync segment of a new bit.
- R11: After reset, all configuration fields are 0, `rx_bit` is 1, and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Controller held in soft reset; opens the configuration and enables hard sync |
| bus_idle | input | 1 | Bus idle; enables hard sync |
| presc_we | input | 1 | Write strobe for the prescaler/jump-width word |
| presc_wdata | input | 8 | SJW in [7:6], BRP in [5:0] |
| tim_we | input | 1 | Write strobe for the timing word |
| tim_wdata | input | 8 | Triple-sample in [7], TS2 in [6:4], TS1 in [3:0] |
| rx_in | input | 1 | Receive line, 1 = recessive |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-clock pulse when rx_bit is updated |
| tx_stb | output | 1 | One-clock pulse at the end of the sync segment |
| bit_start | output | 1 | One-clock pulse when a new bit begins |

## Verification
The hardest situations to reach from the ports are edges that land in one chosen quantum of one chosen segment. Examples are the last quantum of the first phase segment, a second-phase quantum just inside or just outside the jump width, and a second edge in a bit that has already been adjusted. Each scenario waits for an observed `bit_start` pulse. It then counts whole clocks from that pulse and changes `rx_in` half a clock before the chosen quantum boundary. The effect shows up as the distance, in clocks, to the next `bit_start` or `sample_stb` pulse. The majority vote is reached in the same way by raising the line for exactly one or two quanta that end at the sample point.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  localparam int PW_W = SJW_W + BRP_W,
  localparam int TW_W = 1 + TS2_W + TS1_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             presc_we,
  input  logic [PW_W-1:0]  presc_wdata,
  input  logic             tim_we,
  input  logic [TW_W-1:0]  tim_wdata,
  output logic [BRP_W-1:0] brp,
  output logic [SJW_W-1:0] sjw,
  output logic [TS1_W-1:0] tseg1,
  output logic [TS2_W-1:0] tseg2,
  output logic             triple
);

  logic             presc_en, tim_en;
  logic [BRP_W-1:0] brp_n;
  logic [SJW_W-1:0] sjw_n;
  logic [TS1_W-1:0] tseg1_n;
  logic [TS2_W-1:0] tseg2_n;
  logic             triple_n;

  assign presc_en = presc_we & soft_rst;
  assign tim_en   = tim_we & soft_rst;

  always_comb begin
    brp_n    = brp;
    sjw_n    = sjw;
    tseg1_n  = tseg1;
    tseg2_n  = tseg2;
    triple_n = triple;
    if (presc_en) begin
      brp_n = presc_wdata[BRP_W-1:0];
      sjw_n = presc_wdata[PW_W-1:BRP_W];
    end
    if (tim_en) begin
      tseg1_n  = tim_wdata[TS1_W-1:0];
      tseg2_n  = tim_wdata[TS1_W+TS2_W-1:TS1_W];
      triple_n = tim_wdata[TW_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brp    <= '0;
      sjw    <= '0;
      tseg1  <= '0;
      tseg2  <= '0;
      triple <= 1'b0;
    end else begin
      brp    <= brp_n;
      sjw    <= sjw_n;
      tseg1  <= tseg1_n;
      tseg2  <= tseg2_n;
      triple <= triple_n;
    end
  end

  // R3: configuration is frozen outside soft reset
  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (brp == $past(brp)) && (tseg1 == $past(tseg1)) && (sjw == $past(sjw)));

endmodule

// File: rtl/can_bt_tq.sv
module can_bt_tq #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_tick
);

  logic [BRP_W-1:0] cnt, cnt_n;

  assign tq_tick = (cnt >= brp);

  always_comb begin
    if (tq_tick) cnt_n = '0;
    else         cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  // R1: with a prescaler above one, quantum ticks are never back to back
  assert_tq_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && brp != '0 && $stable(brp)) |=> !tq_tick);

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  localparam int Q_W = TS1_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             rx_in,
  input  logic             hsync_en,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] tseg1,
  input  logic [TS2_W-1:0] tseg2,
  input  logic             triple,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             bit_start
);

  seg_e           seg, seg_n;
  logic [Q_W-1:0] q, q_n;
  logic [Q_W-1:0] ts1_len, ts1_len_n;
  logic [Q_W-1:0] ts2_len, ts2_len_n;
  logic [1:0]     hist, hist_n;
  logic           res_done, res_done_n;
  logic           rx_bit_n, sample_n, tx_n, bs_n;

  logic [Q_W-1:0] sjw_q, ts1_base, ts2_base, err1, len1, len2, rem2;
  logic           fall, resync_ok, vote;

  assign sjw_q     = Q_W'(sjw) + Q_W'(1);
  assign ts1_base  = Q_W'(tseg1) + Q_W'(1);
  assign ts2_base  = Q_W'(tseg2) + Q_W'(1);
  assign fall      = tq_tick & hist[0] & ~rx_in;
  assign resync_ok = fall & ~res_done & ~hsync_en;
  assign err1      = q + Q_W'(1);
  assign rem2      = ts2_len - q;
  assign vote      = triple ? ((rx_in & hist[0]) | (rx_in & hist[1]) | (hist[0] & hist[1]))
                            : rx_in;

  always_comb begin
    len1 = ts1_len;
    if (resync_ok) len1 = ts1_len + ((err1 < sjw_q) ? err1 : sjw_q);
    len2 = ts2_len;
    if (resync_ok && rem2 > sjw_q) len2 = ts2_len - sjw_q;
  end

  always_comb begin
    seg_n      = seg;
    q_n        = q;
    ts1_len_n  = ts1_len;
    ts2_len_n  = ts2_len;
    hist_n     = hist;
    res_done_n = res_done;
    rx_bit_n   = rx_bit;
    sample_n   = 1'b0;
    tx_n       = 1'b0;
    bs_n       = 1'b0;
    if (tq_tick) begin
      hist_n = {hist[0], rx_in};
      if (hsync_en && fall) begin
        seg_n      = SEG_TS1;
        q_n        = '0;
        ts1_len_n  = ts1_base;
        res_done_n = 1'b0;
        bs_n       = 1'b1;
        tx_n       = 1'b1;
      end else begin
        unique case (seg)
          SEG_SYNC: begin
            seg_n     = SEG_TS1;
            q_n       = '0;
            ts1_len_n = ts1_base;
            tx_n      = 1'b1;
          end
          SEG_TS1: begin
            ts1_len_n = len1;
            if (resync_ok) res_done_n = 1'b1;
            if (q == len1 - Q_W'(1)) begin
              seg_n     = SEG_TS2;
              q_n       = '0;
              ts2_len_n = ts2_base;
              rx_bit_n  = vote;
              sample_n  = 1'b1;
            end else begin
              q_n = q + Q_W'(1);
            end
          end
          SEG_TS2: begin
            if (resync_ok && rem2 <= sjw_q) begin
              seg_n      = SEG_TS1;
              q_n        = '0;
              ts1_len_n  = ts1_base;
              res_done_n = 1'b0;
              bs_n       = 1'b1;
              tx_n       = 1'b1;
            end else begin
              ts2_len_n = len2;
              if (resync_ok) res_done_n = 1'b1;
              if (q == len2 - Q_W'(1)) begin
                seg_n      = SEG_SYNC;
                q_n        = '0;
                res_done_n = 1'b0;
                bs_n       = 1'b1;
              end else begin
                q_n = q + Q_W'(1);
              end
            end
          end
          default: begin
            seg_n = SEG_SYNC;
            q_n   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg        <= SEG_SYNC;
      q          <= '0;
      ts1_len    <= Q_W'(1);
      ts2_len    <= Q_W'(1);
      hist       <= 2'b11;
      res_done   <= 1'b0;
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      bit_start  <= 1'b0;
    end else begin
      seg        <= seg_n;
      q          <= q_n;
      ts1_len    <= ts1_len_n;
      ts2_len    <= ts2_len_n;
      hist       <= hist_n;
      res_done   <= res_done_n;
      rx_bit     <= rx_bit_n;
      sample_stb <= sample_n;
      tx_stb     <= tx_n;
      bit_start  <= bs_n;
    end
  end

  // R2: the sample point never lands on a bit boundary
  assert_sample_not_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !bit_start);

  // R4: the received bit moves only with a sample strobe
  assert_rxbit_on_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bit != $past(rx_bit)) |-> sample_stb);

  // R6: the quantum index stays inside the (possibly stretched) first segment
  assert_ts1_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS1) |-> (q < ts1_len));

  // R7: shortening never leaves the second segment empty or overrun
  assert_ts2_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_TS2) |-> (q < ts2_len) && (ts2_len != '0));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  localparam int PW_W = SJW_W + BRP_W,
  localparam int TW_W = 1 + TS2_W + TS1_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            bus_idle,
  input  logic            presc_we,
  input  logic [PW_W-1:0] presc_wdata,
  input  logic            tim_we,
  input  logic [TW_W-1:0] tim_wdata,
  input  logic            rx_in,
  output logic            rx_bit,
  output logic            sample_stb,
  output logic            tx_stb,
  output logic            bit_start
);

  logic [BRP_W-1:0] brp;
  logic [SJW_W-1:0] sjw;
  logic [TS1_W-1:0] tseg1;
  logic [TS2_W-1:0] tseg2;
  logic             triple;
  logic             tq_tick;
  logic             hsync_en;

  assign hsync_en = soft_rst | bus_idle;

  can_bt_cfg #(.BRP_W(BRP_W), .SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .presc_we(presc_we), .presc_wdata(presc_wdata),
    .tim_we(tim_we), .tim_wdata(tim_wdata),
    .brp(brp), .sjw(sjw), .tseg1(tseg1), .tseg2(tseg2), .triple(triple)
  );

  can_bt_tq #(.BRP_W(BRP_W)) u_tq (
    .clk(clk), .rst_n(rst_n), .brp(brp), .tq_tick(tq_tick)
  );

  can_bt_seq #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx_in(rx_in),
    .hsync_en(hsync_en), .sjw(sjw), .tseg1(tseg1), .tseg2(tseg2), .triple(triple),
    .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb), .bit_start(bit_start)
  );

endmodule

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, bus_idle, presc_we, tim_we, rx_in;
  logic [7:0] presc_wdata, tim_wdata;
  logic       rx_bit, sample_stb, tx_stb, bit_start;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_idle(bus_idle),
    .presc_we(presc_we), .presc_wdata(presc_wdata),
    .tim_we(tim_we), .tim_wdata(tim_wdata), .rx_in(rx_in),
    .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb), .bit_start(bit_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bs(output int t);
    do @(negedge clk); while (!bit_start);
    t = cyc;
  endtask

  task automatic wait_smp(output int t);
    do @(negedge clk); while (!sample_stb);
    t = cyc;
  endtask

  task automatic wr_presc(input logic [7:0] d);
    @(negedge clk); presc_we = 1'b1; presc_wdata = d;
    @(negedge clk); presc_we = 1'b0;
  endtask

  task automatic wr_tim(input logic [7:0] d);
    @(negedge clk); tim_we = 1'b1; tim_wdata = d;
    @(negedge clk); tim_we = 1'b0;
  endtask

  task automatic bit_len(input string req, input int exp);
    int t0, t1;
    wait_bs(t0);
    wait_bs(t1);
    chk(req, t1 - t0, exp);
  endtask

  task automatic configure(input logic [7:0] p, input logic [7:0] t);
    @(negedge clk); soft_rst = 1'b1;
    wr_presc(p);
    wr_tim(t);
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 rx_bit", rx_bit, 1);
    chk("R11 strobes", {sample_stb, tx_stb, bit_start}, 0);
  endtask

  task automatic t_default_and_lock;
    bit_len("R1 default bit 3 clocks", 3);
    wr_presc(8'h03);
    wr_tim(8'h05);
    bit_len("R3 writes ignored outside soft reset", 3);
  endtask

  task automatic t_prescaled;
    int t0, t1, t2;
    configure(8'h03, 8'h12);
    bit_len("R1 P=4 bit 24 clocks", 24);
    wait_bs(t0);
    wait_smp(t1);
    chk("R2 sample offset", t1 - t0, 16);
    wait_bs(t0);
    do @(negedge clk); while (!tx_stb);
    t2 = cyc;
    chk("R2 tx offset", t2 - t0, 4);
  endtask

  task automatic glitch(input string req, input int pre, input int exp);
    int t0;
    wait_bs(t0);
    repeat (16 - pre) @(negedge clk);
    rx_in = 1'b1;
    repeat (pre) @(negedge clk);
    rx_in = 1'b0;
    chk({req, " strobe"}, sample_stb, 1);
    chk(req, rx_bit, exp);
  endtask

  task automatic t_sampling;
    int t0;
    rx_in = 1'b0;
    wait_bs(t0);
    wait_bs(t0);
    glitch("R4 single sample sees glitch", 1, 1);
    @(negedge clk); soft_rst = 1'b1;
    wr_tim(8'h92);
    @(negedge clk); soft_rst = 1'b0;
    wait_bs(t0);
    glitch("R5 majority rejects one quantum", 1, 0);
    glitch("R5 majority accepts two quanta", 5, 1);
    rx_in = 1'b1;
    wait_bs(t0);
  endtask

  task automatic t_resync;
    int t0, t1;
    configure(8'h40, 8'h35);
    bit_len("R1 P=1 bit 11 clocks", 11);
    // R6: edge in TS1 quantum 3 -> +2 quanta
    wait_bs(t0);
    repeat (4) @(negedge clk); rx_in = 1'b0;
    repeat (2) @(negedge clk); rx_in = 1'b1;
    wait_bs(t1);
    chk("R6 lengthen capped by SJW", t1 - t0, 13);
    // R8: edge in sync segment
    wait_bs(t0);
    rx_in = 1'b0;
    repeat (3) @(negedge clk); rx_in = 1'b1;
    wait_bs(t1);
    chk("R8 sync edge no change", t1 - t0, 11);
    // R9: second edge ignored
    wait_bs(t0);
    @(negedge clk); rx_in = 1'b0;
    @(negedge clk); rx_in = 1'b1;
    @(negedge clk); rx_in = 1'b0;
    repeat (2) @(negedge clk); rx_in = 1'b1;
    wait_bs(t1);
    chk("R9 one adjustment per bit", t1 - t0, 12);
    // R7: TS2 quantum 1, remaining 3 > 2 -> shorten by 2
    wait_bs(t0);
    repeat (8) @(negedge clk); rx_in = 1'b0;
    wait_bs(t1);
    rx_in = 1'b1;
    chk("R7 shorten TS2", t1 - t0, 9);
    // R7: TS2 quantum 2, remaining 2 <= 2 -> becomes sync
    wait_bs(t0);
    repeat (9) @(negedge clk); rx_in = 1'b0;
    wait_bs(t1);
    chk("R7 edge quantum becomes sync", t1 - t0, 10);
    chk("R7 tx_stb with new sync", tx_stb, 1);
    rx_in = 1'b1;
    wait_bs(t0);
    chk("R7 following bit", t0 - t1, 10);
  endtask

  task automatic t_max_sjw;
    int t0, t1, t2;
    configure(8'hC0, 8'h35);
    wait_bs(t0);
    repeat (6) @(negedge clk); rx_in = 1'b0;
    wait_smp(t1);
    rx_in = 1'b1;
    wait_bs(t2);
    chk("R6 sample moved by 4", t1 - t0, 11);
    chk("R6 SJW=4 bit length", t2 - t0, 15);
  endtask

  task automatic t_hard_sync;
    int t0, t1;
    bus_idle = 1'b1;
    wait_bs(t0);
    repeat (3) @(negedge clk); rx_in = 1'b0;
    @(negedge clk);
    chk("R10 hard sync restarts bit", bit_start, 1);
    rx_in = 1'b1;
    wait_bs(t1);
    chk("R10 bit after hard sync", t1 - t0, 14);
    bus_idle = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; bus_idle = 1'b0;
    presc_we = 1'b0; tim_we = 1'b0; presc_wdata = '0; tim_wdata = '0;
    rx_in = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_default_and_lock();
    t_prescaled();
    t_sampling();
    t_resync();
    t_max_sjw();
    t_hard_sync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule